// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Error Flags

This block takes in asynchronous serial characters from one line and places each finished character in a receive buffer. The line is sampled on an oversampling tick that a baud generator outside the block supplies. A character is 7, 8 or 9 data bits long, sent least significant bit first. An optional parity bit and one or two stop bits follow the data. The character length, parity, parity sense and stop-bit count are taken from static configuration inputs. They are captured when a start bit is accepted, so one frame always uses one setting.

The host is modelled by strobes. `rd_data` reads the low buffer byte and empties the buffer. `rd_status` reads the status and clears every error flag. `en_wr`/`en_val` write the receive enable. `init_pulse` re-initialises the receive side. Errors are evaluated in the cycle in which a frame moves into the buffer, and the full flag is raised in that same cycle. An uncleared buffer or an uncleared error flag turns the next completed frame into an overrun.

The frame controller has seven states:
- IDLE waits for a high-to-low edge while receive is enabled, then goes to START.
- START checks the line at mid-bit. A low line leads to DATA and a high line returns to IDLE.
- DATA samples each bit at its centre. After the last bit it goes to PARITY if parity is enabled, otherwise to STOP1.
- PARITY samples the parity bit, then goes to STOP1.
- STOP1 goes to STOP2 when two stop bits are selected, otherwise to XFER.
- STOP2 goes to XFER.
- XFER lasts one cycle, moves the frame to the buffer and returns to IDLE.
- An initialise strobe sends any state back to IDLE.

Top module: `srx_receiver`

## Requirements
- R1: A frame starts only on a high-to-low transition of the synchronised line while receive is enabled. The line must still be low at the sample point halfway through the start bit, or the frame is dropped without touching the buffer.
- R2: Data bits are sampled once per bit at the bit centre and are placed least significant bit first. `char_len` encodes 0 = 7 bits, 1 = 8 bits and 2 = 9 bits; 3 is treated as 8 bits.
- R3: `buf_lo` holds data bits 7:0, with bit 7 forced to 0 for 7-bit characters. `buf_hi` bit 0 holds data bit 8 for 9-bit characters and is 0 otherwise. `buf_hi` bits 7:1 always read 0.
- R4: `buf_full` is set in the cycle a frame enters the buffer and is cleared by `rd_data`.
- R5: With `par_en`=1 a parity bit follows the data. The total count of ones in the data and parity must be even when `par_odd`=0 and odd when `par_odd`=1; otherwise `err_par` is set. With `par_en`=0 no parity bit is expected and `err_par` is never set.
- R6: `err_frm` is set when any expected stop bit (two when `two_stop`=1, one otherwise) is sampled low.
- R7: `err_ovr` is set when a frame completes while `buf_full` or any error flag from before is still set. The new character replaces the buffer contents.
- R8: `err_sum` equals the OR of `err_par`, `err_frm` and `err_ovr`.
- R9: `rd_status` clears `err_par`, `err_frm` and `err_ovr`. It does not change `buf_full`.
- R10: `init_pulse` clears `rx_enabled`, `buf_full` and all error flags, and abandons any frame in progress.
- R11: `en_wr` loads `rx_enabled` from `en_val`. Frames arriving while it is 0 are ignored. Clearing it during a frame lets that frame complete into the buffer, and no later frame is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| os_tick | input | 1 | Oversampling tick, OSR ticks per bit |
| rxd | input | 1 | Serial line, idle high |
| char_len | input | 2 | Character length code (R2) |
| par_en | input | 1 | Parity bit present |
| par_odd | input | 1 | 1 = odd parity, 0 = even |
| two_stop | input | 1 | 1 = two stop bits |
| en_wr | input | 1 | Receive-enable write strobe |
| en_val | input | 1 | Value written by en_wr |
| init_pulse | input | 1 | Receive initialise strobe |
| rd_data | input | 1 | Low buffer byte read strobe |
| rd_status | input | 1 | Status read strobe |
| buf_lo | output | 8 | Buffer low byte |
| buf_hi | output | 8 | Buffer high byte (bit 0 = data bit 8) |
| buf_full | output | 1 | Buffer holds an unread character |
| err_par | output | 1 | Parity error |
| err_frm | output | 1 | Framing error |
| err_ovr | output | 1 | Overrun error |
| err_sum | output | 1 | Any error |
| rx_enabled | output | 1 | Current receive enable |

## Verification
The bench builds the receiver with OSR = 4 and a two-stage synchroniser, and holds the oversampling tick high. Each bit therefore lasts four clocks, and the mid-bit start check falls two samples after the falling edge. This short bit time lets every character length be combined with each parity setting, both stop-bit counts and deliberately corrupted parity and stop bits within a short run. It also leaves room for the sequences that span two frames: overrun from an unread buffer, overrun from an uncleared flag, and initialise or disable arriving in the middle of a frame.

// File: rtl/srx_pkg.sv
package srx_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_START,
        S_DATA,
        S_PARITY,
        S_STOP1,
        S_STOP2,
        S_XFER
    } rx_state_t;

    typedef struct packed {
        logic [1:0] len;
        logic       par_en;
        logic       par_odd;
        logic       two_stop;
    } rx_cfg_t;

    // index of the final data bit for a length code
    function automatic logic [3:0] last_bit_index(input logic [1:0] len);
        unique case (len)
            2'd0:    return 4'd6;
            2'd2:    return 4'd8;
            default: return 4'd7;
        endcase
    endfunction

endpackage

// File: rtl/srx_sync.sv
module srx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_q;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[0] <= 1'b1;
                    else        chain_q[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[i] <= 1'b1;
                    else        chain_q[i] <= chain_q[i-1];
                end
            end
        end
    endgenerate

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/srx_frame_fsm.sv
module srx_frame_fsm
    import srx_pkg::*;
#(
    parameter int OSR = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       rxd,
    input  logic       rx_en,
    input  logic       abort,
    input  rx_cfg_t    cfg_in,
    output logic       xfer,
    output logic [7:0] x_lo,
    output logic [7:0] x_hi,
    output logic       x_pe,
    output logic       x_fe,
    output rx_cfg_t    cfg_q
);
    localparam int CW = (OSR > 2) ? $clog2(OSR) : 1;
    localparam logic [CW-1:0] MID_CNT  = CW'(OSR / 2 - 1);
    localparam logic [CW-1:0] LAST_CNT = CW'(OSR - 1);

    rx_state_t      st_q, st_d;
    logic [CW-1:0]  cnt_q;
    logic [3:0]     idx_q;
    logic [8:0]     sh_q;
    logic           par_q, fe_q, prev_q;
    logic           samp, start_edge, data_done;

    always_comb begin
        samp       = tick && ((st_q == S_START) ? (cnt_q == MID_CNT) : (cnt_q == LAST_CNT));
        start_edge = tick && rx_en && prev_q && !rxd;
        data_done  = (idx_q == last_bit_index(cfg_q.len));
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= S_IDLE;
        else        st_q <= st_d;
    end

    // transitions
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            S_IDLE:   if (start_edge) st_d = S_START;
            S_START:  if (samp) st_d = rxd ? S_IDLE : S_DATA;
            S_DATA:   if (samp && data_done) st_d = cfg_q.par_en ? S_PARITY : S_STOP1;
            S_PARITY: if (samp) st_d = S_STOP1;
            S_STOP1:  if (samp) st_d = cfg_q.two_stop ? S_STOP2 : S_XFER;
            S_STOP2:  if (samp) st_d = S_XFER;
            S_XFER:   st_d = S_IDLE;
            default:  st_d = S_IDLE;
        endcase
        if (abort) st_d = S_IDLE;
    end

    // line history for edge detection
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    prev_q <= 1'b1;
        else if (tick) prev_q <= rxd;
    end

    // sample counter, shifter and error accumulators
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            idx_q <= '0;
            sh_q  <= '0;
            par_q <= 1'b0;
            fe_q  <= 1'b0;
            cfg_q <= '0;
        end else if (abort) begin
            cnt_q <= '0;
        end else if (st_q == S_IDLE) begin
            cnt_q <= '0;
            if (start_edge) begin
                cfg_q <= cfg_in;
                sh_q  <= '0;
                idx_q <= '0;
                par_q <= 1'b0;
                fe_q  <= 1'b0;
            end
        end else if (tick) begin
            cnt_q <= samp ? '0 : cnt_q + 1'b1;
            if (samp) begin
                unique case (st_q)
                    S_DATA: begin
                        sh_q[idx_q] <= rxd;
                        par_q       <= par_q ^ rxd;
                        idx_q       <= idx_q + 4'd1;
                    end
                    S_PARITY: par_q <= par_q ^ rxd;
                    S_STOP1, S_STOP2: if (!rxd) fe_q <= 1'b1;
                    default: ;
                endcase
            end
        end
    end

    // outputs
    always_comb begin
        xfer = (st_q == S_XFER);
        x_lo = {(cfg_q.len == 2'd0) ? 1'b0 : sh_q[7], sh_q[6:0]};
        x_hi = {7'b0, (cfg_q.len == 2'd2) & sh_q[8]};
        x_pe = cfg_q.par_en & (par_q ^ cfg_q.par_odd);
        x_fe = fe_q;
    end
endmodule

// File: rtl/srx_rx_buffer.sv
module srx_rx_buffer (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       xfer,
    input  logic [7:0] x_lo,
    input  logic [7:0] x_hi,
    input  logic       x_pe,
    input  logic       x_fe,
    input  logic       rd_data,
    input  logic       rd_status,
    input  logic       init,
    input  logic       en_wr,
    input  logic       en_val,
    output logic [7:0] buf_lo,
    output logic [7:0] buf_hi,
    output logic       buf_full,
    output logic       err_par,
    output logic       err_frm,
    output logic       err_ovr,
    output logic       err_sum,
    output logic       rx_en
);
    logic prior_full, prior_err, keep_par, keep_frm, keep_ovr;

    always_comb begin
        prior_full = buf_full & ~rd_data;
        keep_par   = err_par & ~rd_status;
        keep_frm   = err_frm & ~rd_status;
        keep_ovr   = err_ovr & ~rd_status;
        prior_err  = keep_par | keep_frm | keep_ovr;
        err_sum    = err_par | err_frm | err_ovr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            buf_lo   <= '0;
            buf_hi   <= '0;
            buf_full <= 1'b0;
            err_par  <= 1'b0;
            err_frm  <= 1'b0;
            err_ovr  <= 1'b0;
            rx_en    <= 1'b0;
        end else if (init) begin
            buf_full <= 1'b0;
            err_par  <= 1'b0;
            err_frm  <= 1'b0;
            err_ovr  <= 1'b0;
            rx_en    <= 1'b0;
        end else begin
            if (en_wr) rx_en <= en_val;
            if (xfer) begin
                buf_lo   <= x_lo;
                buf_hi   <= x_hi;
                buf_full <= 1'b1;
                err_par  <= keep_par | x_pe;
                err_frm  <= keep_frm | x_fe;
                err_ovr  <= keep_ovr | prior_full | prior_err;
            end else begin
                if (rd_data) buf_full <= 1'b0;
                if (rd_status) begin
                    err_par <= 1'b0;
                    err_frm <= 1'b0;
                    err_ovr <= 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/srx_receiver.sv
module srx_receiver
    import srx_pkg::*;
#(
    parameter int OSR         = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       os_tick,
    input  logic       rxd,
    input  logic [1:0] char_len,
    input  logic       par_en,
    input  logic       par_odd,
    input  logic       two_stop,
    input  logic       en_wr,
    input  logic       en_val,
    input  logic       init_pulse,
    input  logic       rd_data,
    input  logic       rd_status,
    output logic [7:0] buf_lo,
    output logic [7:0] buf_hi,
    output logic       buf_full,
    output logic       err_par,
    output logic       err_frm,
    output logic       err_ovr,
    output logic       err_sum,
    output logic       rx_enabled
);
    logic       rxd_s;
    rx_cfg_t    cfg_live, frm_cfg;
    logic       xfer, x_pe, x_fe;
    logic [7:0] x_lo, x_hi;

    always_comb begin
        cfg_live.len      = char_len;
        cfg_live.par_en   = par_en;
        cfg_live.par_odd  = par_odd;
        cfg_live.two_stop = two_stop;
    end

    srx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(rxd), .q(rxd_s)
    );

    srx_frame_fsm #(.OSR(OSR)) u_fsm (
        .clk(clk), .rst_n(rst_n), .tick(os_tick), .rxd(rxd_s),
        .rx_en(rx_enabled), .abort(init_pulse), .cfg_in(cfg_live),
        .xfer(xfer), .x_lo(x_lo), .x_hi(x_hi), .x_pe(x_pe), .x_fe(x_fe),
        .cfg_q(frm_cfg)
    );

    srx_rx_buffer u_buf (
        .clk(clk), .rst_n(rst_n), .xfer(xfer), .x_lo(x_lo), .x_hi(x_hi),
        .x_pe(x_pe), .x_fe(x_fe), .rd_data(rd_data), .rd_status(rd_status),
        .init(init_pulse), .en_wr(en_wr), .en_val(en_val),
        .buf_lo(buf_lo), .buf_hi(buf_hi), .buf_full(buf_full),
        .err_par(err_par), .err_frm(err_frm), .err_ovr(err_ovr),
        .err_sum(err_sum), .rx_en(rx_enabled)
    );
endmodule

// File: rtl/srx_receiver_chk.sv
module srx_receiver_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       init_pulse,
    input logic       rd_data,
    input logic       rd_status,
    input logic       xfer,
    input logic [1:0] cfg_len,
    input logic [7:0] buf_lo,
    input logic [7:0] buf_hi,
    input logic       buf_full,
    input logic       err_par,
    input logic       err_frm,
    input logic       err_ovr,
    input logic       err_sum,
    input logic       rx_enabled
);
    a_r8_sum_is_or: assert property (@(posedge clk) disable iff (!rst_n)
        err_sum == (err_par | err_frm | err_ovr));

    a_r10_init_clears: assert property (@(posedge clk) disable iff (!rst_n)
        init_pulse |=> (!buf_full && !err_par && !err_frm && !err_ovr && !rx_enabled));

    a_r9_status_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_status && !xfer && !init_pulse) |=> (!err_par && !err_frm && !err_ovr));

    a_r4_read_empties: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data && !xfer) |=> !buf_full);

    a_r4_xfer_fills: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer && !init_pulse) |=> buf_full);

    a_r7_overrun_unread: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer && !init_pulse && buf_full && !rd_data) |=> err_ovr);

    a_r3_hi_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        buf_hi[7:1] == 7'd0);

    a_r3_short_msb: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer && !init_pulse && cfg_len == 2'd0) |=> (buf_lo[7] == 1'b0));
endmodule

bind srx_receiver srx_receiver_chk u_chk (
    .clk(clk), .rst_n(rst_n), .init_pulse(init_pulse), .rd_data(rd_data),
    .rd_status(rd_status), .xfer(xfer), .cfg_len(frm_cfg.len),
    .buf_lo(buf_lo), .buf_hi(buf_hi), .buf_full(buf_full),
    .err_par(err_par), .err_frm(err_frm), .err_ovr(err_ovr),
    .err_sum(err_sum), .rx_enabled(rx_enabled)
);

// File: tb/srx_receiver_bench.sv
module srx_receiver_bench;
    localparam int OSR = 4;

    typedef struct packed {
        logic [1:0] len;
        logic       pen;
        logic       podd;
        logic       two;
        logic [8:0] data;
        logic       bpar;
        logic       bstop;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{2'd1, 1'b0, 1'b0, 1'b0, 9'h0A5, 1'b0, 1'b0},
        '{2'd0, 1'b0, 1'b0, 1'b0, 9'h1FF, 1'b0, 1'b0},
        '{2'd2, 1'b0, 1'b0, 1'b0, 9'h155, 1'b0, 1'b0},
        '{2'd1, 1'b1, 1'b0, 1'b0, 9'h03C, 1'b0, 1'b0},
        '{2'd1, 1'b1, 1'b1, 1'b0, 9'h081, 1'b1, 1'b0},
        '{2'd1, 1'b0, 1'b0, 1'b1, 9'h0C3, 1'b0, 1'b1},
        '{2'd2, 1'b1, 1'b1, 1'b1, 9'h1A3, 1'b0, 1'b0},
        '{2'd0, 1'b1, 1'b0, 1'b0, 9'h02A, 1'b1, 1'b0},
        '{2'd3, 1'b0, 1'b0, 1'b0, 9'h000, 1'b0, 1'b1}
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic os_tick = 1'b1, rxd = 1'b1;
    logic [1:0] char_len = 2'd1;
    logic par_en = 1'b0, par_odd = 1'b0, two_stop = 1'b0;
    logic en_wr = 1'b0, en_val = 1'b0, init_pulse = 1'b0;
    logic rd_data = 1'b0, rd_status = 1'b0;
    logic [7:0] buf_lo, buf_hi;
    logic buf_full, err_par, err_frm, err_ovr, err_sum, rx_enabled;

    int checks = 0, fails = 0;

    always #2 clk = ~clk;

    srx_receiver #(.OSR(OSR), .SYNC_STAGES(2)) u_srx_receiver (
        .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rxd(rxd),
        .char_len(char_len), .par_en(par_en), .par_odd(par_odd),
        .two_stop(two_stop), .en_wr(en_wr), .en_val(en_val),
        .init_pulse(init_pulse), .rd_data(rd_data), .rd_status(rd_status),
        .buf_lo(buf_lo), .buf_hi(buf_hi), .buf_full(buf_full),
        .err_par(err_par), .err_frm(err_frm), .err_ovr(err_ovr),
        .err_sum(err_sum), .rx_enabled(rx_enabled)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int nbits(input logic [1:0] len);
        return (len == 2'd0) ? 7 : (len == 2'd2) ? 9 : 8;
    endfunction

    // one bit time; act 1 = initialise, 2 = disable, on its first cycle
    task automatic hold_bit(input logic v, input int act);
        rxd = v;
        if (act == 1) init_pulse = 1'b1;
        if (act == 2) begin en_wr = 1'b1; en_val = 1'b0; end
        @(negedge clk);
        init_pulse = 1'b0;
        en_wr = 1'b0;
        repeat (OSR - 1) @(negedge clk);
    endtask

    task automatic send_frame(input logic [8:0] d, input logic bpar, input logic bstop, input int act);
        int n;
        logic ones;
        n = nbits(char_len);
        ones = 1'b0;
        hold_bit(1'b0, 0);
        for (int i = 0; i < n; i++) begin
            ones ^= d[i];
            hold_bit(d[i], (i == 3) ? act : 0);
        end
        if (par_en) hold_bit(ones ^ par_odd ^ bpar, 0);
        hold_bit(~bstop, 0);
        if (two_stop) hold_bit(1'b1, 0);
        rxd = 1'b1;
        repeat (3 * OSR) @(negedge clk);
    endtask

    task automatic strobe_read(input logic data_rd, input logic stat_rd);
        rd_data = data_rd;
        rd_status = stat_rd;
        @(negedge clk);
        rd_data = 1'b0;
        rd_status = 1'b0;
        @(negedge clk);
    endtask

    task automatic set_enable(input logic v);
        en_wr = 1'b1;
        en_val = v;
        @(negedge clk);
        en_wr = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [7:0] elo, ehi;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // reset state
        check("R4 reset buf_full", {15'd0, buf_full}, 16'd0);
        check("R8 reset err_sum", {15'd0, err_sum}, 16'd0);
        check("R11 reset rx_enabled", {15'd0, rx_enabled}, 16'd0);
        check("R3 reset buf_hi", {8'd0, buf_hi}, 16'd0);

        // R11: disabled receiver ignores a frame
        send_frame(9'h05A, 1'b0, 1'b0, 0);
        check("R11 disabled ignores frame", {15'd0, buf_full}, 16'd0);

        set_enable(1'b1);
        check("R11 enable written", {15'd0, rx_enabled}, 16'd1);

        // R1: short low glitch is not a start bit
        rxd = 1'b0;
        @(negedge clk);
        rxd = 1'b1;
        repeat (8 * OSR) @(negedge clk);
        check("R1 glitch rejected", {15'd0, buf_full}, 16'd0);

        // table walk
        for (int v = 0; v < NV; v++) begin
            char_len = VECS[v].len;
            par_en   = VECS[v].pen;
            par_odd  = VECS[v].podd;
            two_stop = VECS[v].two;
            send_frame(VECS[v].data, VECS[v].bpar, VECS[v].bstop, 0);
            elo = VECS[v].data[7:0];
            if (VECS[v].len == 2'd0) elo[7] = 1'b0;
            ehi = {7'd0, (VECS[v].len == 2'd2) & VECS[v].data[8]};
            check("R2 R3 buf_lo", {8'd0, buf_lo}, {8'd0, elo});
            check("R3 buf_hi", {8'd0, buf_hi}, {8'd0, ehi});
            check("R4 buf_full set", {15'd0, buf_full}, 16'd1);
            check("R5 parity flag", {15'd0, err_par}, {15'd0, VECS[v].pen & VECS[v].bpar});
            check("R6 framing flag", {15'd0, err_frm}, {15'd0, VECS[v].bstop});
            check("R8 summary flag", {15'd0, err_sum},
                  {15'd0, (VECS[v].pen & VECS[v].bpar) | VECS[v].bstop});
            strobe_read(1'b1, 1'b1);
            check("R4 read empties", {15'd0, buf_full}, 16'd0);
            check("R9 status clears", {13'd0, err_par, err_frm, err_ovr}, 16'd0);
        end

        // R7: overrun from an unread buffer
        char_len = 2'd1; par_en = 1'b0; two_stop = 1'b0;
        send_frame(9'h011, 1'b0, 1'b0, 0);
        send_frame(9'h022, 1'b0, 1'b0, 0);
        check("R7 overrun unread", {15'd0, err_ovr}, 16'd1);
        check("R7 new data kept", {8'd0, buf_lo}, 16'h0022);
        check("R8 sum on overrun", {15'd0, err_sum}, 16'd1);
        strobe_read(1'b0, 1'b1);
        check("R9 status keeps full", {15'd0, buf_full}, 16'd1);
        check("R9 overrun cleared", {15'd0, err_ovr}, 16'd0);
        strobe_read(1'b1, 1'b0);

        // R7: overrun from an uncleared flag
        send_frame(9'h033, 1'b0, 1'b1, 0);
        strobe_read(1'b1, 1'b0);
        send_frame(9'h044, 1'b0, 1'b0, 0);
        check("R7 overrun stale flag", {15'd0, err_ovr}, 16'd1);
        check("R6 framing stays", {15'd0, err_frm}, 16'd1);
        strobe_read(1'b1, 1'b1);

        // R10: initialise during a frame
        send_frame(9'h0F0, 1'b0, 1'b0, 1);
        check("R10 frame abandoned", {15'd0, buf_full}, 16'd0);
        check("R10 enable cleared", {15'd0, rx_enabled}, 16'd0);
        check("R10 flags clear", {15'd0, err_sum}, 16'd0);

        // R11: disable during a frame
        set_enable(1'b1);
        send_frame(9'h09C, 1'b0, 1'b0, 2);
        check("R11 frame finishes", {15'd0, buf_full}, 16'd1);
        check("R11 data of finished frame", {8'd0, buf_lo}, 16'h009C);
        check("R11 enable now low", {15'd0, rx_enabled}, 16'd0);
        strobe_read(1'b1, 1'b1);
        send_frame(9'h066, 1'b0, 1'b0, 0);
        check("R11 later frame ignored", {15'd0, buf_full}, 16'd0);
        check("R11 buffer unchanged", {8'd0, buf_lo}, 16'h009C);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule